// File: doc/BRIEF.md
# Reset Cause Capture Register

This block records which reset sources have fired since software last cleared the record. There are six sources: power-on or low-voltage, the external reset pin, main-clock stop detection, sub-clock stop detection, a software request and a watchdog overflow. Each source drives a one-cycle pulse input. Each pulse sets a sticky status bit. The bits accumulate, so several resets that happen before software reads the record all remain visible. A power event is dominant: once its bit is set, the other bits carry no meaning.

Software reads the bits over a small request/response register port, using one of two addresses. The inspect address returns the bits and leaves them untouched. The drain address returns the same bits and clears them in the cycle after the request is accepted. The port uses valid/ready on both sides:

- A request is accepted on a clock edge where `req_valid` and `req_ready` are both high.
- The response is held in a single register until `rsp_ready` takes it.
- `req_ready` is low while a response is waiting and `rsp_ready` is low. A stalled consumer therefore back-pressures new requests, and no read is lost or duplicated.

The pulse inputs are assumed to be synchronous to `clk`. The status bits are also brought straight out on `cause_o`.

Top module: `rcc_top`

## Requirements
- R1: After `rst_n` is released, `cause_o` is 0 and `rsp_valid` is 0.
- R2: A pulse on a source sets its bit in the cycle after the pulse and leaves every other bit as it was. Bit positions: 0 power, 1 external pin, 2 main-clock stop, 3 sub-clock stop, 4 software, 5 watchdog.
- R3: Pulses arriving in different cycles, or in the same cycle, all leave their bits set until a drain read.
- R4: A power pulse sets bit 0. While bit 0 is 1, bits 5..1 have no defined meaning and readers ignore them; this model drives them to 0 unless a pulse sets them.
- R5: A read accepted at the inspect address (default 0) returns the bits in `rsp_data[5:0]`, with all upper data bits 0, and leaves the bits unchanged.
- R6: A read accepted at the drain address (default 1) returns the bits as they were before the read, and the bits are 0 in the cycle after acceptance.
- R7: A source pulse in the same cycle as an accepted drain read wins. Its bit is 1 afterwards, and the response still shows the pre-read value.
- R8: While `rsp_valid` is 1 and `rsp_ready` is 0, `rsp_data` holds steady and `req_ready` is 0.
- R9: A read at any other address returns 0 and changes no bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Asynchronous active-low initialisation |
| pwr_evt | input | 1 | Power-on / low-voltage reset pulse |
| ext_evt | input | 1 | External reset pin pulse |
| mclk_evt | input | 1 | Main-clock stop detection pulse |
| sclk_evt | input | 1 | Sub-clock stop detection pulse |
| sw_evt | input | 1 | Software reset request pulse |
| wdt_evt | input | 1 | Watchdog overflow pulse |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Port can accept a request |
| req_addr | input | ADDR_W | Read address |
| rsp_valid | output | 1 | Response data present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_data | output | DATA_W | Read data |
| cause_o | output | 6 | Live cause bits |

## Verification
The drain read and a source pulse can land in the same clock edge. The clear and the set then compete for one bit. The bench provokes this by raising a watchdog pulse in the exact cycle its drain request is accepted. It judges two things: the queued response must show the pre-read bits, and `cause_o` one cycle later must hold only the watchdog bit. A second collision pairs a power pulse with a pulse on another source, and the other source's bit must survive.

// File: rtl/rcc_pkg.sv
package rcc_pkg;
  localparam int unsigned NCAUSE = 6;

  typedef enum int unsigned {
    CS_PWR  = 0,
    CS_EXT  = 1,
    CS_MCLK = 2,
    CS_SCLK = 3,
    CS_SW   = 4,
    CS_WDT  = 5
  } cause_idx_e;
endpackage

// File: rtl/rcc_cause_bank.sv
module rcc_cause_bank #(
  parameter int unsigned N       = rcc_pkg::NCAUSE,
  parameter int unsigned DOM_IDX = rcc_pkg::CS_PWR
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] evt_i,
  input  logic         clr_i,
  output logic [N-1:0] bits_o
);
  logic [N-1:0] bits_q;
  logic         dom_hit;

  assign dom_hit = evt_i[DOM_IDX];

  for (genvar i = 0; i < N; i++) begin : g_bit
    logic nxt;
    if (i == DOM_IDX) begin : g_dom
      // dominant source: only a drain read clears it
      always_comb nxt = evt_i[i] | (bits_q[i] & ~clr_i);
    end else begin : g_sub
      // subordinate source: own pulse sets; drain or dominant pulse zeroes
      always_comb nxt = evt_i[i] | (bits_q[i] & ~clr_i & ~dom_hit);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) bits_q[i] <= 1'b0;
      else        bits_q[i] <= nxt;
    end
  end

  assign bits_o = bits_q;
endmodule

// File: rtl/rcc_bus_port.sv
module rcc_bus_port #(
  parameter int unsigned N          = rcc_pkg::NCAUSE,
  parameter int unsigned ADDR_W     = 2,
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned PLAIN_ADDR = 0,
  parameter int unsigned CLEAR_ADDR = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_data,
  input  logic [N-1:0]      bits_i,
  output logic              clr_o
);
  localparam logic [ADDR_W-1:0] A_PLAIN = ADDR_W'(PLAIN_ADDR);
  localparam logic [ADDR_W-1:0] A_CLEAR = ADDR_W'(CLEAR_ADDR);

  logic              accept;
  logic              hit;
  logic [DATA_W-1:0] widened;
  logic [DATA_W-1:0] rd_word;
  logic              vld_q;
  logic [DATA_W-1:0] dat_q;

  assign req_ready = ~vld_q | rsp_ready;
  assign accept    = req_valid & req_ready;
  assign hit       = (req_addr == A_PLAIN) | (req_addr == A_CLEAR);
  assign clr_o     = accept & (req_addr == A_CLEAR);

  always_comb begin
    widened         = '0;
    widened[N-1:0]  = bits_i;
    rd_word         = hit ? widened : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      dat_q <= '0;
    end else if (accept) begin
      vld_q <= 1'b1;
      dat_q <= rd_word;
    end else if (rsp_ready) begin
      vld_q <= 1'b0;
    end
  end

  assign rsp_valid = vld_q;
  assign rsp_data  = dat_q;
endmodule

// File: rtl/rcc_top.sv
module rcc_top #(
  parameter int unsigned ADDR_W     = 2,
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned PLAIN_ADDR = 0,
  parameter int unsigned CLEAR_ADDR = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwr_evt,
  input  logic              ext_evt,
  input  logic              mclk_evt,
  input  logic              sclk_evt,
  input  logic              sw_evt,
  input  logic              wdt_evt,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_data,
  output logic [5:0]        cause_o
);
  import rcc_pkg::*;

  logic [NCAUSE-1:0] evt_vec;
  logic [NCAUSE-1:0] bits;
  logic              clr;

  always_comb begin
    evt_vec          = '0;
    evt_vec[CS_PWR]  = pwr_evt;
    evt_vec[CS_EXT]  = ext_evt;
    evt_vec[CS_MCLK] = mclk_evt;
    evt_vec[CS_SCLK] = sclk_evt;
    evt_vec[CS_SW]   = sw_evt;
    evt_vec[CS_WDT]  = wdt_evt;
  end

  rcc_cause_bank #(.N(NCAUSE), .DOM_IDX(CS_PWR)) u_bank (
    .clk    (clk),
    .rst_n  (rst_n),
    .evt_i  (evt_vec),
    .clr_i  (clr),
    .bits_o (bits)
  );

  rcc_bus_port #(
    .N(NCAUSE), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .PLAIN_ADDR(PLAIN_ADDR), .CLEAR_ADDR(CLEAR_ADDR)
  ) u_port (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_addr  (req_addr),
    .rsp_valid (rsp_valid),
    .rsp_ready (rsp_ready),
    .rsp_data  (rsp_data),
    .bits_i    (bits),
    .clr_o     (clr)
  );

  assign cause_o = bits;
endmodule

// File: rtl/rcc_top_chk.sv
module rcc_top_chk #(
  parameter int unsigned ADDR_W     = 2,
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned CLEAR_ADDR = 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pwr_evt,
  input logic              ext_evt,
  input logic              mclk_evt,
  input logic              sclk_evt,
  input logic              sw_evt,
  input logic              wdt_evt,
  input logic              req_valid,
  input logic              req_ready,
  input logic [ADDR_W-1:0] req_addr,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [DATA_W-1:0] rsp_data,
  input logic [5:0]        cause_o
);
  logic [5:0] ev;
  logic       drain;
  assign ev    = {wdt_evt, sw_evt, sclk_evt, mclk_evt, ext_evt, pwr_evt};
  assign drain = req_valid & req_ready & (req_addr == ADDR_W'(CLEAR_ADDR));

  // R2 / R3: every pulsed bit is set next cycle
  p_pulse_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ev != 6'd0) |=> ((cause_o & $past(ev)) == $past(ev)));

  // R2 / R5: no pulse and no drain leaves the bits unchanged
  p_quiet_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ev == 6'd0 && !drain) |=> $stable(cause_o));

  // R4: power pulse alone sets bit 0
  p_power_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_evt |=> cause_o[0]);

  // R6: drain with no pulse empties the bits
  p_drain_empties_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (drain && ev == 6'd0) |=> (cause_o == 6'd0));

  // R7: a pulse colliding with a drain survives
  p_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (drain && ev != 6'd0) |=> ((cause_o & $past(ev)) == $past(ev)));

  // R8: stalled response stays put
  p_rsp_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));

  // R8: stalled response blocks requests
  p_backpress_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !req_ready);

  // R5: upper data bits are zero
  p_upper_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_data[DATA_W-1:6] == '0));
endmodule

bind rcc_top rcc_top_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CLEAR_ADDR(CLEAR_ADDR)
) u_chk (.*);

// File: tb/sim_rcc_top.sv
module sim_rcc_top;
  localparam int unsigned AW = 2;
  localparam int unsigned DW = 8;
  localparam logic [AW-1:0] A_PLAIN = 2'd0;
  localparam logic [AW-1:0] A_CLEAR = 2'd1;
  localparam logic [AW-1:0] A_OTHER = 2'd3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [5:0] ev = '0;
  logic req_valid = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic rsp_ready = 1'b1;
  logic req_ready, rsp_valid;
  logic [DW-1:0] rsp_data;
  logic [5:0] cause_o;

  always #4 clk = ~clk;

  rcc_top u0 (
    .clk(clk), .rst_n(rst_n),
    .pwr_evt(ev[0]), .ext_evt(ev[1]), .mclk_evt(ev[2]),
    .sclk_evt(ev[3]), .sw_evt(ev[4]), .wdt_evt(ev[5]),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .cause_o(cause_o)
  );

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 1'b0;
  logic [DW-1:0] exp_q[$];
  string tag_q[$];
  logic [5:0] mdl = '0;

  task automatic check(input logic [DW-1:0] act, input logic [DW-1:0] exp, input string tag);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // driver: single-cycle pulse on chosen sources
  task automatic pulse(input logic [5:0] m);
    @(negedge clk); ev = m;
    @(negedge clk); ev = '0;
    if (m[0]) mdl = m;      // power: others undefined, model as pulsed only
    else      mdl = mdl | m;
  endtask

  // driver: read request, pushes expected response
  task automatic rd(input logic [AW-1:0] a, input string tag);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a;
    while (!req_ready) @(negedge clk);
    exp_q.push_back((a == A_PLAIN || a == A_CLEAR) ? {2'b00, mdl} : '0);
    tag_q.push_back(tag);
    @(negedge clk);
    req_valid = 1'b0;
    if (a == A_CLEAR) mdl = '0;
  endtask

  // monitor: compare each response at its handshake
  always @(negedge clk) begin
    if (rst_n && rsp_valid && rsp_ready) begin
      if (exp_q.size() == 0) begin
        n_vec++; n_bad++;
        $display("FAIL R5 unexpected response actual=%h expected=none", rsp_data);
      end else begin
        check(rsp_data, exp_q.pop_front(), tag_q.pop_front());
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check({2'b00, cause_o}, 8'h00, "R1 cause after reset");
    check({7'd0, rsp_valid}, 8'h01 & 8'h00, "R1 rsp_valid after reset");

    pulse(6'b000010);
    check({2'b00, cause_o}, 8'h02, "R2 external pin sets bit1");
    pulse(6'b010000);
    check({2'b00, cause_o}, 8'h12, "R3 software accumulates");
    pulse(6'b101000);
    check({2'b00, cause_o}, 8'h3A, "R3 same-cycle pulses accumulate");

    rd(A_PLAIN, "R5 inspect returns bits");
    @(negedge clk);
    check({2'b00, cause_o}, 8'h3A, "R5 inspect leaves bits");

    rd(A_OTHER, "R9 unmapped reads zero");
    @(negedge clk);
    check({2'b00, cause_o}, 8'h3A, "R9 unmapped leaves bits");

    rd(A_CLEAR, "R6 drain returns pre-read bits");
    check({2'b00, cause_o}, 8'h00, "R6 bits empty after drain");

    // R7: watchdog pulse collides with accepted drain
    pulse(6'b000100);
    @(negedge clk);
    req_valid = 1'b1; req_addr = A_CLEAR; ev = 6'b100000;
    exp_q.push_back(8'h04); tag_q.push_back("R7 collision response pre-read");
    @(negedge clk);
    req_valid = 1'b0; ev = '0; mdl = 6'b100000;
    check({2'b00, cause_o}, 8'h20, "R7 set wins over drain");

    // R4: power dominant; bits 5..1 are don't-care while bit0 set
    pulse(6'b010010);
    pulse(6'b000001);
    check({7'd0, cause_o[0]}, 8'h01, "R4 power sets bit0");
    rd(A_CLEAR, "R6 drain after power");
    pulse(6'b001001);
    check({2'b00, cause_o & 6'b001001}, 8'h09, "R4 power with sub-clock pulse");
    rd(A_CLEAR, "R6 drain after power pair");

    // R8: stall the consumer
    pulse(6'b000100);
    @(negedge clk);
    rsp_ready = 1'b0;
    req_valid = 1'b1; req_addr = A_PLAIN;
    exp_q.push_back(8'h04); tag_q.push_back("R8 stalled response delivered");
    @(negedge clk);
    req_valid = 1'b0;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check({7'd0, rsp_valid}, 8'h01, "R8 rsp_valid held");
      check(rsp_data, 8'h04, "R8 rsp_data stable");
      check({7'd0, req_ready}, 8'h00, "R8 req_ready low while stalled");
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check({7'd0, rsp_valid}, 8'h00, "R8 response drained");
    check({7'd0, req_ready}, 8'h01, "R8 req_ready restored");

    repeat (3) @(negedge clk);
    check(DW'(exp_q.size()), 8'h00, "R5 all responses seen");
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule